// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address to a real address through a small set of block-translation register pairs. There is one bank of pairs for instruction fetches and a separate bank for data loads and stores. Each pair describes one naturally aligned block of between 128 KB and 256 MB. The upper word of a pair gives the block's effective base, a length mask and two privilege-valid bits. The lower word gives the real base, the storage-control bits (WIMG) and a 2-bit protection code.

For each request the unit first picks the bank from the access type. It then tests every pair of that bank for privilege validity and address match in parallel. The lowest-numbered valid matching pair supplies the translation. If relocation is off for the access type, the effective address is passed straight through and no check is made. Pairs are loaded through a simple word-wide write port. Results appear on registered outputs one cycle after the request.

A two-state controller drives the response. The states are `ST_IDLE`, where no response is presented, and `ST_RESP`, where the captured result is valid. The transition IDLE→RESP is taken on a request. RESP→RESP is taken on a back-to-back request. RESP→IDLE is taken when no request arrives.

Top module: `bat_xlate_unit`

## Requirements
- R1: `req_kind` 00 is a fetch and searches only the instruction bank. Codes 01 (load), 10 (store) and 11 (treated as a store) search only the data bank. A write to a pair takes `wr_bank` 0 for the instruction bank and 1 for the data bank.
- R2: Bit 31 is the most significant bit, and `wr_upper`=1 writes the upper word. In the upper word, [31:17] is the effective block index, [12:2] the length mask, [1] supervisor-valid and [0] user-valid. In the lower word, [31:17] is the real block index, [6:3] WIMG and [1:0] the protection code. On a hit, `rsp_wimg` equals the lower word's [6:3].
- R3: A pair matches when {ea[31:28], ea[27:17] & ~mask} equals its effective block index. A set mask bit doubles the block length, starting from 2^17 bytes.
- R4: On a hit, `rsp_ra` = {rpn[14:11], rpn[10:0] | (ea[27:17] & mask), ea[16:0]}. The low 17 address bits always pass through unchanged.
- R5: A pair takes part only if it is privilege-valid: supervisor-valid while `user_mode`=0, or user-valid while `user_mode`=1.
- R6: With relocation off for the access type (`msr_ir` for fetches, `msr_dr` for loads and stores), `rsp_ra` equals the effective address and `rsp_hit`, `rsp_fault` and `rsp_wimg` are 0.
- R7: Protection code 00 faults every access. Codes 01 and 11 fault only stores. Code 10 faults nothing. `rsp_fault` is never set without `rsp_hit`.
- R8: When several valid pairs match, the lowest-numbered one supplies the translation.
- R9: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1, and 0 otherwise.
- R10: A request in the same cycle as a write sees the old pair contents. The next request sees the new contents.
- R11: After reset every pair is cleared, so no pair is valid, and all response outputs are 0.
- R12: With relocation on and no valid matching pair, `rsp_hit` is 0, `rsp_fault` is 0, `rsp_wimg` is 0 and `rsp_ra` equals the effective address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one word of a pair |
| wr_bank | input | 1 | 0 instruction bank, 1 data bank |
| wr_idx | input | 2 | Pair index within the bank |
| wr_upper | input | 1 | 1 upper word, 0 lower word |
| wr_data | input | 32 | Word to write |
| req_valid | input | 1 | Translation request |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access type code |
| msr_ir | input | 1 | Relocation enable for fetches |
| msr_dr | input | 1 | Relocation enable for loads/stores |
| user_mode | input | 1 | 1 user state, 0 supervisor state |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A pair translated the address |
| rsp_ra | output | 32 | Real address |
| rsp_wimg | output | 4 | Storage-control bits of the hit pair |
| rsp_fault | output | 1 | Protection violation |

## Verification
Every result of a request is due at the first rising edge after the request is driven. The bench drives each request at a falling edge and lets one rising edge pass. It compares all five response outputs at the next falling edge, then drops `req_valid`. It then samples `rsp_valid` one full cycle later to see that it has fallen. A write issued together with a request is judged on that same response and again on the following request.

// File: rtl/bat_pkg.sv
package bat_pkg;
    localparam int EA_W   = 32;
    localparam int PG_W   = 15;
    localparam int MSK_W  = 11;
    localparam int HI_W   = PG_W - MSK_W;
    localparam int OFS_W  = EA_W - PG_W;

    localparam int UP_MSK_LSB  = 2;
    localparam int UP_SUP_BIT  = 1;
    localparam int UP_USR_BIT  = 0;
    localparam int LO_WIMG_LSB = 3;
    localparam int LO_PP_LSB   = 0;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
    import bat_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_bank,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic                            wr_upper,
    input  logic [EA_W-1:0]                 wr_data,
    input  logic                            rd_bank,
    output logic [NUM_PAIRS-1:0][EA_W-1:0]  rd_upper,
    output logic [NUM_PAIRS-1:0][EA_W-1:0]  rd_lower
);
    logic [1:0][NUM_PAIRS-1:0][EA_W-1:0] up_q;
    logic [1:0][NUM_PAIRS-1:0][EA_W-1:0] lo_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
            logic sel;
            assign sel = wr_en && (wr_bank == b[0]) && (wr_idx == IDX_W'(i));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    up_q[b][i] <= '0;
                    lo_q[b][i] <= '0;
                end else if (sel) begin
                    if (wr_upper) up_q[b][i] <= wr_data;
                    else          lo_q[b][i] <= wr_data;
                end
            end
        end
    end

    assign rd_upper = up_q[rd_bank];
    assign rd_lower = lo_q[rd_bank];
endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
    import bat_pkg::*;
(
    input  logic [EA_W-1:0] ea,
    input  logic [EA_W-1:0] upper,
    input  logic [EA_W-1:0] lower,
    input  logic            user_mode,
    output logic            hit,
    output logic [EA_W-1:0] ra,
    output logic [3:0]      wimg,
    output logic [1:0]      pp
);
    logic [PG_W-1:0]  eff_idx;
    logic [PG_W-1:0]  real_idx;
    logic [MSK_W-1:0] len_mask;
    logic [MSK_W-1:0] ea_mid;
    logic             addr_ok;
    logic             priv_ok;

    assign eff_idx  = upper[EA_W-1 -: PG_W];
    assign real_idx = lower[EA_W-1 -: PG_W];
    assign len_mask = upper[UP_MSK_LSB +: MSK_W];
    assign ea_mid   = ea[OFS_W +: MSK_W];

    assign addr_ok = ({ea[EA_W-1 -: HI_W], ea_mid & ~len_mask} == eff_idx);
    assign priv_ok = user_mode ? upper[UP_USR_BIT] : upper[UP_SUP_BIT];
    assign hit     = addr_ok && priv_ok;

    assign ra   = {real_idx[PG_W-1 -: HI_W],
                   real_idx[MSK_W-1:0] | (ea_mid & len_mask),
                   ea[OFS_W-1:0]};
    assign wimg = lower[LO_WIMG_LSB +: 4];
    assign pp   = lower[LO_PP_LSB +: 2];
endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel #(
    parameter int NUM_PAIRS = 4
) (
    input  logic [NUM_PAIRS-1:0] cand,
    output logic [NUM_PAIRS-1:0] grant,
    output logic                 any
);
    always_comb begin
        grant = '0;
        for (int k = NUM_PAIRS - 1; k >= 0; k--) begin
            if (cand[k]) grant = NUM_PAIRS'(1) << k;
        end
    end

    assign any = |cand;
endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit
    import bat_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_upper,
    input  logic [EA_W-1:0]  wr_data,
    input  logic             req_valid,
    input  logic [EA_W-1:0]  req_ea,
    input  logic [1:0]       req_kind,
    input  logic             msr_ir,
    input  logic             msr_dr,
    input  logic             user_mode,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [EA_W-1:0]  rsp_ra,
    output logic [3:0]       rsp_wimg,
    output logic             rsp_fault
);
    acc_kind_e  kind;
    logic       is_fetch;
    logic       is_write;
    logic       reloc;

    assign kind     = acc_kind_e'(req_kind);
    assign is_fetch = (kind == ACC_FETCH);
    assign is_write = (kind == ACC_STORE) || (kind == ACC_RSVD);
    assign reloc    = is_fetch ? msr_ir : msr_dr;

    logic [NUM_PAIRS-1:0][EA_W-1:0] bank_up;
    logic [NUM_PAIRS-1:0][EA_W-1:0] bank_lo;

    bat_regfile #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_idx   (wr_idx),
        .wr_upper (wr_upper),
        .wr_data  (wr_data),
        .rd_bank  (!is_fetch),
        .rd_upper (bank_up),
        .rd_lower (bank_lo)
    );

    logic [NUM_PAIRS-1:0]           e_hit;
    logic [NUM_PAIRS-1:0][EA_W-1:0] e_ra;
    logic [NUM_PAIRS-1:0][3:0]      e_wimg;
    logic [NUM_PAIRS-1:0][1:0]      e_pp;

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_match
        bat_entry_match u_match (
            .ea        (req_ea),
            .upper     (bank_up[i]),
            .lower     (bank_lo[i]),
            .user_mode (user_mode),
            .hit       (e_hit[i]),
            .ra        (e_ra[i]),
            .wimg      (e_wimg[i]),
            .pp        (e_pp[i])
        );
    end

    logic [NUM_PAIRS-1:0] grant;
    logic                 any_hit;

    bat_prio_sel #(.NUM_PAIRS(NUM_PAIRS)) u_prio (
        .cand  (e_hit),
        .grant (grant),
        .any   (any_hit)
    );

    logic [EA_W-1:0] sel_ra;
    logic [3:0]      sel_wimg;
    logic [1:0]      sel_pp;

    always_comb begin
        sel_ra   = '0;
        sel_wimg = '0;
        sel_pp   = '0;
        for (int k = 0; k < NUM_PAIRS; k++) begin
            if (grant[k]) begin
                sel_ra   = sel_ra   | e_ra[k];
                sel_wimg = sel_wimg | e_wimg[k];
                sel_pp   = sel_pp   | e_pp[k];
            end
        end
    end

    logic            nx_hit;
    logic            nx_fault;
    logic [EA_W-1:0] nx_ra;
    logic [3:0]      nx_wimg;

    always_comb begin
        nx_hit   = reloc && any_hit;
        nx_ra    = nx_hit ? sel_ra : req_ea;
        nx_wimg  = nx_hit ? sel_wimg : 4'b0000;
        nx_fault = nx_hit && ((sel_pp == 2'b00) || (sel_pp[0] && is_write));
    end

    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_ra    <= '0;
            rsp_wimg  <= '0;
            rsp_fault <= 1'b0;
        end else if (req_valid) begin
            rsp_hit   <= nx_hit;
            rsp_ra    <= nx_ra;
            rsp_wimg  <= nx_wimg;
            rsp_fault <= nx_fault;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: rsp_valid = 1'b0;
            ST_RESP: rsp_valid = 1'b1;
        endcase
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R9
    AST_REAL_MODE_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !reloc) |=> (rsp_ra == $past(req_ea) && !rsp_hit && !rsp_fault)); // R6
    AST_OFFSET_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_ra[OFS_W-1:0] == $past(req_ea[OFS_W-1:0]))); // R4
    AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> rsp_hit); // R7
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8
    AST_GRANT_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~e_hit) == '0) && (any_hit == (grant != '0))); // R8
endmodule

// File: tb/tb_bat_xlate_unit.sv
`timescale 1ns/1ps
module tb_bat_xlate_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_bank, wr_upper;
    logic [1:0]  wr_idx;
    logic [31:0] wr_data;
    logic        req_valid;
    logic [31:0] req_ea;
    logic [1:0]  req_kind;
    logic        msr_ir, msr_dr, user_mode;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [31:0] rsp_ra;
    logic [3:0]  rsp_wimg;

    always #2 clk = ~clk;

    bat_xlate_unit dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_upper(wr_upper), .wr_data(wr_data),
        .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind),
        .msr_ir(msr_ir), .msr_dr(msr_dr), .user_mode(user_mode),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ra(rsp_ra),
        .rsp_wimg(rsp_wimg), .rsp_fault(rsp_fault)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] m_up [2][4];
    logic [31:0] m_lo [2][4];
    logic [31:0] ea_list [8];

    function automatic logic [31:0] mk_up(logic [31:0] base, logic [10:0] mask, logic sv, logic uv);
        return {base[31:17], 4'b0000, mask, sv, uv};
    endfunction

    function automatic logic [31:0] mk_lo(logic [31:0] rbase, logic [3:0] wimg, logic [1:0] pp);
        return {rbase[31:17], 10'b0, wimg, 1'b0, pp};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] ea, input logic [1:0] kind, input logic ir, input logic dr,
                         input logic usr, output logic hit, output logic [31:0] ra,
                         output logic [3:0] wimg, output logic flt);
        int b;
        logic rel;
        logic [31:0] up, lo, span, base;
        logic ok;
        logic [1:0] pp;
        b = (kind == 2'b00) ? 0 : 1;
        rel = (kind == 2'b00) ? ir : dr;
        hit = 0; ra = ea; wimg = 0; flt = 0;
        if (rel) begin
            for (int i = 0; i < 4; i++) begin
                up = m_up[b][i];
                lo = m_lo[b][i];
                ok = usr ? up[0] : up[1];
                span = 32'd1 << (17 + $countones(up[12:2]));
                base = {up[31:17], 17'b0};
                if (!hit && ok && ((ea & ~(span - 1)) == base)) begin
                    hit = 1;
                    ra = {lo[31:17], 17'b0} + (ea & (span - 1));
                    wimg = lo[6:3];
                    pp = lo[1:0];
                    flt = (pp == 2'b00) || (pp[0] && kind[1]);
                end
            end
        end
    endtask

    task automatic write_pair_word(logic bank, logic [1:0] idx, logic up, logic [31:0] data);
        wr_en = 1; wr_bank = bank; wr_idx = idx; wr_upper = up; wr_data = data;
        @(negedge clk);
        wr_en = 0;
        if (up) m_up[bank][idx] = data; else m_lo[bank][idx] = data;
    endtask

    task automatic load_pair(logic bank, logic [1:0] idx, logic [31:0] u, logic [31:0] l);
        write_pair_word(bank, idx, 1'b1, u);
        write_pair_word(bank, idx, 1'b0, l);
    endtask

    task automatic do_req(string req, logic [31:0] ea, logic [1:0] kind, logic ir, logic dr, logic usr);
        logic eh, ef;
        logic [31:0] er;
        logic [3:0] ew;
        model(ea, kind, ir, dr, usr, eh, er, ew, ef);
        req_valid = 1; req_ea = ea; req_kind = kind; msr_ir = ir; msr_dr = dr; user_mode = usr;
        @(posedge clk);
        @(negedge clk);
        chk(req, "valid", {31'b0, rsp_valid}, 32'd1);
        chk(req, "hit", {31'b0, rsp_hit}, {31'b0, eh});
        chk(req, "ra", rsp_ra, er);
        chk(req, "wimg", {28'b0, rsp_wimg}, {28'b0, ew});
        chk(req, "fault", {31'b0, rsp_fault}, {31'b0, ef});
        req_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_bank = 0; wr_idx = 0; wr_upper = 0; wr_data = 0;
        req_valid = 0; req_ea = 0; req_kind = 0; msr_ir = 0; msr_dr = 0; user_mode = 0;
        for (int b = 0; b < 2; b++) for (int i = 0; i < 4; i++) begin m_up[b][i] = 0; m_lo[b][i] = 0; end
        ea_list[0] = 32'h1000_0000; ea_list[1] = 32'h1005_4321;
        ea_list[2] = 32'h1001_FFFF; ea_list[3] = 32'h1008_0000;
        ea_list[4] = 32'h4001_2345; ea_list[5] = 32'h4002_0000;
        ea_list[6] = 32'h1003_0001; ea_list[7] = 32'hFFFF_FFFC;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11: reset state at the ports
        chk("R11", "valid", {31'b0, rsp_valid}, 32'd0);
        chk("R11", "hit", {31'b0, rsp_hit}, 32'd0);
        chk("R11", "ra", rsp_ra, 32'd0);
        chk("R11", "wimg", {28'b0, rsp_wimg}, 32'd0);
        chk("R11", "fault", {31'b0, rsp_fault}, 32'd0);
        // R11 / R12: cleared pairs never hit
        do_req("R11 R12", 32'h1000_0000, 2'b01, 1'b1, 1'b1, 1'b0);
        chk("R11 R12", "miss-hit", {31'b0, rsp_hit}, 32'd0);

        // data bank
        load_pair(1'b1, 2'd0, mk_up(32'h1000_0000, 11'h003, 1'b1, 1'b0), mk_lo(32'h2000_0000, 4'b0101, 2'b10));
        load_pair(1'b1, 2'd1, mk_up(32'h4000_0000, 11'h000, 1'b1, 1'b1), mk_lo(32'h0012_0000, 4'b0010, 2'b01));
        load_pair(1'b1, 2'd2, mk_up(32'h1000_0000, 11'h000, 1'b1, 1'b0), mk_lo(32'h3000_0000, 4'b1111, 2'b10));
        load_pair(1'b1, 2'd3, mk_up(32'h1000_0000, 11'h7FF, 1'b0, 1'b1), mk_lo(32'h5000_0000, 4'b1001, 2'b00));
        // instruction bank
        load_pair(1'b0, 2'd0, mk_up(32'h1000_0000, 11'h001, 1'b1, 1'b1), mk_lo(32'h7000_0000, 4'b1000, 2'b01));
        load_pair(1'b0, 2'd1, mk_up(32'h0000_0000, 11'h7FF, 1'b0, 1'b1), mk_lo(32'h8000_0000, 4'b0011, 2'b10));

        // Sweep: all kinds, privilege states, relocate combinations, addresses
        for (int k = 0; k < 3; k++)
            for (int u = 0; u < 2; u++)
                for (int r = 0; r < 4; r++)
                    for (int e = 0; e < 8; e++)
                        do_req("R1 R2 R3 R4 R5 R6 R7 R8 R12", ea_list[e], 2'(k), r[0], r[1], u[0]);

        // R8: overlap of pairs 0 and 2, pair 0 wins
        do_req("R8", 32'h1000_1234, 2'b01, 1'b0, 1'b1, 1'b0);
        chk("R8", "ra-low-pair", rsp_ra, 32'h2000_1234);
        // R5: user state skips supervisor-only pairs, reaches pair 3 (code 00)
        do_req("R5 R7", 32'h1000_1234, 2'b01, 1'b0, 1'b1, 1'b1);
        chk("R5 R7", "ra-user", rsp_ra, 32'h5000_1234);
        chk("R5 R7", "fault-00", {31'b0, rsp_fault}, 32'd1);
        // R1: fetch uses the instruction bank
        do_req("R1", 32'h1000_1234, 2'b00, 1'b1, 1'b0, 1'b0);
        chk("R1", "ra-fetch", rsp_ra, 32'h7000_1234);
        // R7: code 11 treated as store on a read-only pair
        do_req("R7", 32'h4001_2345, 2'b11, 1'b0, 1'b1, 1'b0);
        chk("R7", "fault-ro-store", {31'b0, rsp_fault}, 32'd1);
        // R9: no request -> rsp_valid drops
        @(negedge clk);
        chk("R9", "valid-idle", {31'b0, rsp_valid}, 32'd0);

        // R10: write in the same cycle as a request; old contents used
        wr_en = 1; wr_bank = 1; wr_idx = 2'd1; wr_upper = 0;
        wr_data = mk_lo(32'h0012_0000, 4'b0010, 2'b10);
        req_valid = 1; req_ea = 32'h4001_2345; req_kind = 2'b10; msr_ir = 0; msr_dr = 1; user_mode = 0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        chk("R10", "fault-old", {31'b0, rsp_fault}, 32'd1);
        m_lo[1][1] = wr_data;
        do_req("R10", 32'h4001_2345, 2'b10, 1'b0, 1'b1, 1'b0);
        chk("R10", "fault-new", {31'b0, rsp_fault}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule